// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Decoder

This block decodes a telephone keypad tone pair from two already-limited logic inputs: one square wave for the low-frequency group and one for the high-frequency group. Each input is synchronised to `clk`. The block counts `clk` cycles between successive rising edges to measure the period of each input. It then places that period into one of four frequency bins for its group. Each bin is an acceptance window of ±`TOL_PPT` parts per thousand around the nominal period `CLK_HZ / f`. Default frequencies: low group 697, 770, 852 and 941 Hz; high group 1209, 1336, 1477 and 1633 Hz, each list in ascending order.

A group tracker state machine guards each group, so that a signal such as speech, whose period wanders, does not register as a tone. The tracker states are `TRK_HUNT` (no candidate), `TRK_BUILD` (counting consecutive periods in one bin) and `TRK_LOCK` (group valid). Transitions:
- *start*: HUNT→BUILD on an in-window period.
- *extend*: BUILD→BUILD on the same bin.
- *restart*: BUILD→BUILD, or LOCK→BUILD, on a period in a different bin.
- *confirm*: BUILD→LOCK when the `RUN_LEN`th consecutive matching period arrives.
- *hold*: LOCK→LOCK on the locked bin.
- *miss*: any state→HUNT on an out-of-window period.
- *stale*: any state→HUNT when no rising edge arrives for longer than the longest accepted period of the group.

`tone_present` is high while both trackers are in LOCK. `key_code` carries the 4-bit code of the last pair seen while `tone_present` was high.

Top module: `dtmf_period_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release with no tone applied, `tone_present` is 0 and `key_code` is 4'b0000.
- R2: A period, measured in `clk` cycles between synchronised rising edges, is accepted for frequency f when it lies in [floor(CLK_HZ·(1000−TOL_PPT)/(1000·f)), floor(CLK_HZ·(1000+TOL_PPT)/(1000·f))]. Steady tones with periods inside these windows produce `tone_present` = 1.
- R3: A group becomes valid only on its `RUN_LEN`th (default 4) consecutive period in the same bin. `tone_present` is still 0 just before that rising edge is seen, and is 1 a few cycles after it. The input synchroniser has two stages.
- R4: With a valid tone on only one input, `tone_present` stays 0.
- R5: A single out-of-window period on a locked group drops `tone_present` within a few cycles of the rising edge that ends it. A fresh run of `RUN_LEN` matching periods restores it.
- R6: If a group sees no rising edge for longer than its longest accepted period, its valid status clears and `tone_present` falls.
- R7: A tone whose period alternates between two different bins on every cycle never becomes valid.
- R8: `key_code` takes the code of the pair on the cycle after `tone_present` is high. Row is the low bin (0 = lowest frequency), column is the high bin. Row 0 gives 1, 2, 3, 13. Row 1 gives 4, 5, 6, 14. Row 2 gives 7, 8, 9, 15. Row 3 gives 11, 10, 12, 0.
- R9: While `tone_present` is 0, `key_code` holds its last value.
- R10: Periods in the gaps between windows, for example 5% away from a nominal value, are rejected: `tone_present` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_tone_in | input | 1 | Limited low-group tone, asynchronous |
| high_tone_in | input | 1 | Limited high-group tone, asynchronous |
| tone_present | output | 1 | Both groups hold a valid frequency |
| key_code | output | 4 | Code of the last valid pair |

## Verification
Errors in the per-group period counter or a bin boundary show as a wrong `key_code` row or column, or as a missing `tone_present`. They appear once `RUN_LEN` periods of the slower tone have elapsed, a little over a thousand cycles. A tracker that counts its run wrongly moves the rise of `tone_present` by one full low-group period. The bench therefore samples just before and just after the expected edge. A tracker that fails to leave LOCK on a miss or on silence keeps `tone_present` high. This shows up within a dozen cycles of the bad period, or within one longest period of the tone stopping.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    typedef enum logic [1:0] {
        TRK_HUNT  = 2'd0,
        TRK_BUILD = 2'd1,
        TRK_LOCK  = 2'd2
    } trk_state_e;

    // Window edge, in clock cycles, for frequency f_hz at tolerance tol_ppt
    function automatic int win_bound(input int clk_hz, input int f_hz,
                                     input int tol_ppt, input bit upper);
        longint num;
        longint den;
        num = longint'(clk_hz) * (upper ? longint'(1000 + tol_ppt)
                                        : longint'(1000 - tol_ppt));
        den = longint'(f_hz) * 1000;
        return int'(num / den);
    endfunction

    // Row = low-group bin, column = high-group bin
    function automatic logic [3:0] pair_code(input logic [1:0] row,
                                             input logic [1:0] col);
        logic [3:0] r4;
        logic [3:0] c4;
        r4 = {2'b00, row};
        c4 = {2'b00, col};
        if (col == 2'd3)
            return 4'd13 + r4;
        else if (row != 2'd3)
            return (r4 * 4'd3) + c4 + 4'd1;
        else if (col == 2'd0)
            return 4'd11;
        else if (col == 2'd1)
            return 4'd10;
        else
            return 4'd12;
    endfunction

endpackage

// File: rtl/tone_edge_sync.sv
module tone_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    output logic rise
);
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[SYNC_STAGES-1:0], tone_in};
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R2
    rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/period_binner.sv
module period_binner #(
    parameter int               CLK_HZ  = 200000,
    parameter int               TOL_PPT = 25,
    parameter logic [3:0][15:0] FREQS   = {16'd941, 16'd852, 16'd770, 16'd697}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    output logic       hit,
    output logic [1:0] bin,
    output logic       stale
);
    import dtmf_pkg::*;

    localparam int CMAX_I = win_bound(CLK_HZ, int'(FREQS[0]), TOL_PPT, 1'b1) + 1;
    localparam int CW     = $clog2(CMAX_I + 1);
    localparam logic [CW-1:0] CMAX = CW'(CMAX_I);

    logic [CW-1:0] cnt_q;
    logic [3:0]    in_bin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CMAX;
        else if (rise)
            cnt_q <= CW'(1);
        else if (cnt_q != CMAX)
            cnt_q <= cnt_q + CW'(1);
    end

    for (genvar i = 0; i < 4; i++) begin : g_win
        localparam logic [CW-1:0] LO = CW'(win_bound(CLK_HZ, int'(FREQS[i]), TOL_PPT, 1'b0));
        localparam logic [CW-1:0] HI = CW'(win_bound(CLK_HZ, int'(FREQS[i]), TOL_PPT, 1'b1));
        assign in_bin[i] = (cnt_q >= LO) && (cnt_q <= HI);
    end

    always_comb begin
        bin = 2'd0;
        for (int i = 0; i < 4; i++)
            if (in_bin[i]) bin = 2'(i);
    end

    assign hit   = |in_bin;
    assign stale = (cnt_q == CMAX);

    // R2
    one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_bin) <= 1);
    // R6
    stale_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale |-> !hit);

endmodule

// File: rtl/group_tracker.sv
module group_tracker #(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_evt,
    input  logic       hit,
    input  logic [1:0] bin,
    input  logic       stale,
    output logic       locked,
    output logic [1:0] lock_bin
);
    import dtmf_pkg::*;

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_DONE = RW'(RUN_LEN);
    localparam trk_state_e FIRST_STATE = (RUN_LEN == 1) ? TRK_LOCK : TRK_BUILD;

    trk_state_e    state_q, state_d;
    logic [1:0]    cand_q, cand_d;
    logic [RW-1:0] run_q, run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_HUNT;
            cand_q  <= 2'd0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        run_d   = run_q;
        unique case (state_q)
            TRK_HUNT: begin
                if (per_evt && hit) begin
                    cand_d  = bin;
                    run_d   = RW'(1);
                    state_d = FIRST_STATE;
                end
            end
            TRK_BUILD: begin
                if (stale || (per_evt && !hit)) begin
                    state_d = TRK_HUNT;
                    run_d   = '0;
                end else if (per_evt && bin == cand_q) begin
                    run_d = run_q + RW'(1);
                    if (run_q + RW'(1) == RUN_DONE)
                        state_d = TRK_LOCK;
                end else if (per_evt) begin
                    cand_d = bin;
                    run_d  = RW'(1);
                end
            end
            TRK_LOCK: begin
                if (stale || (per_evt && !hit)) begin
                    state_d = TRK_HUNT;
                    run_d   = '0;
                end else if (per_evt && bin != cand_q) begin
                    cand_d  = bin;
                    run_d   = RW'(1);
                    state_d = FIRST_STATE;
                end
            end
            default: begin
                state_d = TRK_HUNT;
                run_d   = '0;
            end
        endcase
    end

    always_comb begin
        locked   = (state_q == TRK_LOCK);
        lock_bin = cand_q;
    end

    // R5
    miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && per_evt && !hit) |=> !locked);
    // R6
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> !locked);
    // R3
    lock_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(per_evt && hit));
    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_DONE);

endmodule

// File: rtl/dtmf_period_decoder.sv
module dtmf_period_decoder #(
    parameter int               CLK_HZ      = 200000,
    parameter int               TOL_PPT     = 25,
    parameter int               RUN_LEN     = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [3:0][15:0] LOW_HZ      = {16'd941, 16'd852, 16'd770, 16'd697},
    parameter logic [3:0][15:0] HIGH_HZ     = {16'd1633, 16'd1477, 16'd1336, 16'd1209}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_tone_in,
    input  logic       high_tone_in,
    output logic       tone_present,
    output logic [3:0] key_code
);
    import dtmf_pkg::*;

    localparam int GROUPS = 2;

    logic [GROUPS-1:0]      tone_vec;
    logic [GROUPS-1:0]      grp_valid;
    logic [GROUPS-1:0][1:0] grp_bin;
    logic [3:0]             key_q;

    assign tone_vec = {high_tone_in, low_tone_in};

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam logic [3:0][15:0] FSET = (g == 0) ? LOW_HZ : HIGH_HZ;
        logic       rise;
        logic       hit;
        logic       stale;
        logic [1:0] bin;

        tone_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tone_in (tone_vec[g]),
            .rise    (rise)
        );

        period_binner #(.CLK_HZ(CLK_HZ), .TOL_PPT(TOL_PPT), .FREQS(FSET)) u_bin (
            .clk   (clk),
            .rst_n (rst_n),
            .rise  (rise),
            .hit   (hit),
            .bin   (bin),
            .stale (stale)
        );

        group_tracker #(.RUN_LEN(RUN_LEN)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .per_evt  (rise),
            .hit      (hit),
            .bin      (bin),
            .stale    (stale),
            .locked   (grp_valid[g]),
            .lock_bin (grp_bin[g])
        );
    end

    assign tone_present = &grp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_q <= 4'd0;
        else if (tone_present)
            key_q <= pair_code(grp_bin[0], grp_bin[1]);
    end

    assign key_code = key_q;

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_present |=> $stable(key_code));
    // R8
    pair_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_present && $past(tone_present)) |-> $stable(grp_bin));

endmodule

// File: tb/dtmf_period_decoder_test.sv
module dtmf_period_decoder_test;

    localparam int CLK_HZ = 200000;
    localparam int RUN    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_tone_in = 1'b0;
    logic       high_tone_in = 1'b0;
    logic       tone_present;
    logic [3:0] key_code;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_key = 0;

    int lo_req = 0, lo_alt = 0, lo_cur = 0, lo_c = 0;
    int hi_req = 0, hi_cur = 0, hi_c = 0;
    bit lo_ph = 1'b0;

    dtmf_period_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_tone_in  (low_tone_in),
        .high_tone_in (high_tone_in),
        .tone_present (tone_present),
        .key_code     (key_code)
    );

    always #4 clk = ~clk;

    // Low-group generator, optional alternating second period
    always @(negedge clk) begin
        if (lo_req == 0) begin
            low_tone_in <= 1'b0;
            lo_c <= 0;
        end else if (lo_c == 0) begin
            lo_cur <= (lo_alt != 0 && lo_ph) ? lo_alt : lo_req;
            lo_ph <= ~lo_ph;
            low_tone_in <= 1'b1;
            lo_c <= 1;
        end else begin
            low_tone_in <= (lo_c < lo_cur / 2);
            lo_c <= (lo_c + 1 >= lo_cur) ? 0 : lo_c + 1;
        end
    end

    always @(negedge clk) begin
        if (hi_req == 0) begin
            high_tone_in <= 1'b0;
            hi_c <= 0;
        end else if (hi_c == 0) begin
            hi_cur <= hi_req;
            high_tone_in <= 1'b1;
            hi_c <= 1;
        end else begin
            high_tone_in <= (hi_c < hi_cur / 2);
            hi_c <= (hi_c + 1 >= hi_cur) ? 0 : hi_c + 1;
        end
    end

    function automatic int low_f(input int r);
        case (r)
            0: return 697;
            1: return 770;
            2: return 852;
            default: return 941;
        endcase
    endfunction

    function automatic int high_f(input int c);
        case (c)
            0: return 1209;
            1: return 1336;
            2: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic int nom_per(input int f);
        return (CLK_HZ + f / 2) / f;
    endfunction

    // Keypad table: rows 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D
    function automatic int exp_key(input int r, input int c);
        int t [16] = '{1, 2, 3, 13, 4, 5, 6, 14, 7, 8, 9, 15, 11, 10, 12, 0};
        return t[r * 4 + c];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply a pair, check result, then remove both tones and check release
    task automatic play(input int lp, input int hp, input bit want, input int wkey,
                        input string req);
        int mx;
        mx = (lp > hp) ? lp : hp;
        if (mx == 0) mx = 300;
        lo_req = lp;
        hi_req = hp;
        wait_cyc((RUN + 2) * mx + 30);
        chk(tone_present == want, req, tone_present, want);
        if (want) begin
            chk(key_code == wkey, req, key_code, wkey);
            last_key = wkey;
        end
        lo_req = 0;
        hi_req = 0;
        wait_cyc(700);
        chk(tone_present == 1'b0, "R6", tone_present, 0);
        chk(key_code == last_key, "R9", key_code, last_key);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        wait_cyc(5);
        // R1 during reset
        chk(tone_present == 1'b0, "R1", tone_present, 0);
        chk(key_code == 4'd0, "R1", key_code, 0);
        rst_n = 1'b1;
        wait_cyc(400);
        chk(tone_present == 1'b0, "R1", tone_present, 0);
        chk(key_code == 4'd0, "R1", key_code, 0);

        // R3: exact lock instant on key 1 (697 / 1209)
        lo_req = 287;
        hi_req = 165;
        @(posedge low_tone_in);
        wait_cyc(RUN * 287 - 3);
        chk(tone_present == 1'b0, "R3", tone_present, 0);
        wait_cyc(12);
        chk(tone_present == 1'b1, "R3", tone_present, 1);
        chk(key_code == 4'd1, "R8", key_code, 1);
        last_key = 1;

        // R5: one out-of-window low period (270) drops presence
        @(posedge low_tone_in);
        lo_req = 270;
        @(posedge low_tone_in);
        lo_req = 287;
        @(posedge low_tone_in);
        wait_cyc(10);
        chk(tone_present == 1'b0, "R5", tone_present, 0);
        wait_cyc((RUN + 1) * 287);
        chk(tone_present == 1'b1, "R5", tone_present, 1);

        // R6 / R9: silence
        lo_req = 0;
        hi_req = 0;
        wait_cyc(700);
        chk(tone_present == 1'b0, "R6", tone_present, 0);
        chk(key_code == 4'd1, "R9", key_code, 1);

        // R8 / R2: every key at nominal periods
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                play(nom_per(low_f(r)), nom_per(high_f(c)), 1'b1, exp_key(r, c), "R8");

        // R4: single group only
        play(287, 0, 1'b0, 0, "R4");
        play(0, 149, 1'b0, 0, "R4");

        // R10: periods in the gaps
        play(270, 165, 1'b0, 0, "R10");
        play(287, 157, 1'b0, 0, "R10");

        // R7: low period alternating between two bins
        lo_alt = 260;
        play(287, 165, 1'b0, 0, "R7");
        lo_alt = 0;

        // R2: random keys with period deviation up to 1.5%
        for (int k = 0; k < 10; k++) begin
            int r, c, lp, hp, jl, jh;
            r = int'($urandom_range(0, 3));
            c = int'($urandom_range(0, 3));
            lp = nom_per(low_f(r));
            hp = nom_per(high_f(c));
            jl = lp * 15 / 1000;
            jh = hp * 15 / 1000;
            lp = lp + int'($urandom_range(0, 2 * jl)) - jl;
            hp = hp + int'($urandom_range(0, 2 * jh)) - jh;
            play(lp, hp, 1'b1, exp_key(r, c), "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule